// File: doc/BRIEF.md
# Shared-Pin Boundary-Scan and Serial Programming Port

This block lets four device pins serve two masters. While the select input is high, the pins form a boundary-scan test access port: mode select, data in, test clock and data out. The port holds a small instruction register and decodes BYPASS, EXTEST and SAMPLE over a boundary register. That register covers every three-state pad and every input-only pad. While the select input is low, the same pins feed a serial programming interface instead. The clock pin shifts a parallel word, the data-in pin supplies its bits, and the data-out pin returns them. A high mode pin at a clock edge raises a control strobe for the programming sequencer that sits outside this block.

A falling edge on the select input enters programming mode. In that mode every pad output enable is forced off. When the select input returns high, programming mode ends and the test port restarts from Test-Logic-Reset. All pin inputs are oversampled on the system clock. Pin clock edges are found by a synchronizer followed by an edge detector. The pin clock must therefore run well below the system clock.

Top module: `dual_use_test_port`

## Requirements
- R1: With `sel_jtag` high, `pin_ms`, `pin_di`, `pin_ck` and `pin_do` act as the test port's mode select, data in, clock and data out. Clock pulses in this state leave `prog_data` unchanged.
- R2: The test port steps through the standard 16-state controller on each rising edge of the test clock. Holding mode select high for five clocks reaches Test-Logic-Reset from any state, which cancels EXTEST.
- R3: The instruction register is 2 bits wide and is shifted LSB first. Its codes are EXTEST = 00, SAMPLE = 01 and BYPASS = 11. Code 10 behaves as BYPASS. Capture-IR loads 01, and Test-Logic-Reset selects BYPASS.
- R4: In BYPASS, a one-bit register captures 0 and then delays the data-in stream by one shift.
- R5: The boundary register holds 3*N_TRI + N_IN cells, with cell 0 nearest data out. For three-state pad k, cell 3k is the pad input, cell 3k+1 the core output and cell 3k+2 the core enable. Input-only pad j uses cell 3*N_TRI + j. SAMPLE and EXTEST capture all of these cells.
- R6: Under EXTEST, `pad_out[k]` and `pad_oe[k]` come from the update copy of cells 3k+1 and 3k+2, which is loaded at Update-DR. Under any other instruction, the pads follow `sys_out` and `sys_oe`.
- R7: Data out changes only on a falling test-clock edge. `pin_do_en` is high only after a falling edge seen in Shift-DR or Shift-IR, and is low otherwise.
- R8: A high-to-low transition of `sel_jtag` sets `prog_mode`, which drives every `pad_oe` bit low.
- R9: When `sel_jtag` returns high, `prog_mode` clears and the test port is back in Test-Logic-Reset with BYPASS selected.
- R10: With `sel_jtag` low, each rising `pin_ck` edge with `pin_ms` low shifts `pin_di` into the MSB of `prog_data` (a right shift). `pin_do` shows `prog_data[0]`, and `pin_do_en` is high.
- R11: With `sel_jtag` low, a rising `pin_ck` edge with `pin_ms` high leaves `prog_data` unchanged. It pulses `prog_ctl_valid` for one system clock, with `prog_ctl_bit` equal to `pin_di`.
- R12: Holding `trst_n` low forces the test port into Test-Logic-Reset and selects BYPASS, whatever the clock and mode-select pins are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the pins |
| rst_n | input | 1 | Active-low asynchronous system reset |
| trst_n | input | 1 | Active-low test-port reset pin |
| sel_jtag | input | 1 | Pin function select: high = test port, low = programming |
| pin_ms | input | 1 | Shared mode-select / programming-control pin |
| pin_di | input | 1 | Shared serial data input pin |
| pin_ck | input | 1 | Shared test / programming clock pin |
| pin_do | output | 1 | Shared serial data output pin value |
| pin_do_en | output | 1 | Output enable for pin_do |
| prog_mode | output | 1 | Programming mode flag; forces all pad enables off |
| prog_data | output | PROG_W | Programming shift register contents |
| prog_ctl_valid | output | 1 | One-cycle control strobe for the programming sequencer |
| prog_ctl_bit | output | 1 | Data-in value captured with the control strobe |
| sys_out | input | N_TRI | Core output values for three-state pads |
| sys_oe | input | N_TRI | Core output enables for three-state pads |
| pad_in | input | N_TRI+N_IN | Values seen at all pads (three-state first, then input-only) |
| pad_out | output | N_TRI | Values driven toward three-state pads |
| pad_oe | output | N_TRI | Enables driven toward three-state pads |

## Verification
The assertions assume that every pin moves slowly against the system clock. Each pin-clock phase lasts several system clocks, and the mode-select and data pins are settled before the clock pin moves. This keeps edge detection and state updates in separate clock cycles. The stimulus respects this by holding every pin phase for eight system clocks. It changes `sel_jtag` and `trst_n` only while the pin clock is low and idle.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   function automatic tap_state_e tap_next(tap_state_e s, logic tms);
      tap_state_e n;
      case (s)
         ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
         default:   n = ST_TLR;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tpp_pin_sync.sv
module tpp_pin_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tpp_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg <= {STAGES{RST_VAL}};
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/tpp_tap_fsm.sv
module tpp_tap_fsm
   import tpp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       step,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_TLR;
      end else if (hold) begin
         state <= ST_TLR;
      end else if (step) begin
         state <= tap_next(state, tms);
      end
   end

   // R12 / R9: a held controller sits in Test-Logic-Reset next cycle
   p_hold_tlr_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> state == ST_TLR);

   // R2: the controller moves only on a test-clock rising edge
   p_step_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !hold) |=> $stable(state));

   // R2: mode select high keeps Test-Logic-Reset
   p_tlr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TLR && tms) |=> state == ST_TLR);

endmodule

// File: rtl/tpp_bscan_chain.sv
module tpp_bscan_chain #(
   parameter int N_TRI = 4,
   parameter int N_IN  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  capture,
   input  logic                  shift,
   input  logic                  update,
   input  logic                  tdi,
   input  logic [N_TRI+N_IN-1:0] pad_in,
   input  logic [N_TRI-1:0]      sys_out,
   input  logic [N_TRI-1:0]      sys_oe,
   output logic                  tdo_bit,
   output logic [N_TRI-1:0]      upd_out,
   output logic [N_TRI-1:0]      upd_oe
);

   localparam int LEN = 3 * N_TRI + N_IN;

   generate
      if (N_TRI < 1 || N_IN < 0) begin : g_bad_counts
         $error("tpp_bscan_chain: need at least one three-state pad");
      end
   endgenerate

   logic [LEN-1:0] cap_vec;
   logic [LEN-1:0] sh;

   generate
      for (genvar k = 0; k < N_TRI; k++) begin : g_tri_cell
         assign cap_vec[3*k]   = pad_in[k];
         assign cap_vec[3*k+1] = sys_out[k];
         assign cap_vec[3*k+2] = sys_oe[k];
      end
      if (N_IN > 0) begin : g_in_cells
         for (genvar j = 0; j < N_IN; j++) begin : g_in_cell
            assign cap_vec[3*N_TRI+j] = pad_in[N_TRI+j];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh <= '0;
      end else if (capture) begin
         sh <= cap_vec;
      end else if (shift) begin
         sh <= {tdi, sh[LEN-1:1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_out <= '0;
         upd_oe  <= '0;
      end else if (update) begin
         for (int k = 0; k < N_TRI; k++) begin
            upd_out[k] <= sh[3*k+1];
            upd_oe[k]  <= sh[3*k+2];
         end
      end
   end

   assign tdo_bit = sh[0];

   // R5: each shift moves data-in into the far end of the chain
   p_chain_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !capture) |=> sh[LEN-1] == $past(tdi));

   // R5: capture takes the first pad input into the cell nearest data out
   p_chain_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> sh[0] == $past(pad_in[0]));

endmodule

// File: rtl/tpp_prog_shifter.sv
module tpp_prog_shifter #(
   parameter int PROG_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              edge_rise,
   input  logic              mode,
   input  logic              sdi,
   output logic [PROG_W-1:0] data,
   output logic              ctl_valid,
   output logic              ctl_bit
);

   logic do_shift;
   logic do_ctl;
   logic [PROG_W-1:0] nxt;

   assign do_shift = en && edge_rise && !mode;
   assign do_ctl   = en && edge_rise && mode;

   generate
      if (PROG_W == 1) begin : g_one_bit
         assign nxt = sdi;
      end else begin : g_wide
         assign nxt = {sdi, data[PROG_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data <= '0;
      end else if (do_shift) begin
         data <= nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_valid <= 1'b0;
         ctl_bit   <= 1'b0;
      end else begin
         ctl_valid <= do_ctl;
         if (do_ctl) begin
            ctl_bit <= sdi;
         end
      end
   end

   // R10: a data edge lands the serial bit in the MSB
   p_shift_in_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (en && edge_rise && !mode) |=> data[PROG_W-1] == $past(sdi));

   // R11: a control edge leaves the word alone and raises the strobe
   p_ctl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && edge_rise && mode) |=> ($stable(data) && ctl_valid));

   // R1: nothing shifts while the pins belong to the test port
   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(data));

endmodule

// File: rtl/dual_use_test_port.sv
module dual_use_test_port
   import tpp_pkg::*;
#(
   parameter int N_TRI       = 4,
   parameter int N_IN        = 2,
   parameter int PROG_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int IR_W        = 2,
   parameter int SAMPLE_CODE = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  trst_n,
   input  logic                  sel_jtag,
   input  logic                  pin_ms,
   input  logic                  pin_di,
   input  logic                  pin_ck,
   output logic                  pin_do,
   output logic                  pin_do_en,
   output logic                  prog_mode,
   output logic [PROG_W-1:0]     prog_data,
   output logic                  prog_ctl_valid,
   output logic                  prog_ctl_bit,
   input  logic [N_TRI-1:0]      sys_out,
   input  logic [N_TRI-1:0]      sys_oe,
   input  logic [N_TRI+N_IN-1:0] pad_in,
   output logic [N_TRI-1:0]      pad_out,
   output logic [N_TRI-1:0]      pad_oe
);

   localparam logic [IR_W-1:0] IR_BYP = '1;
   localparam logic [IR_W-1:0] IR_EXT = '0;
   localparam logic [IR_W-1:0] IR_SMP = IR_W'(SAMPLE_CODE);
   localparam logic [IR_W-1:0] IR_CAP = IR_W'(1);

   generate
      if (IR_W < 2) begin : g_bad_irw
         $error("dual_use_test_port: IR_W must be at least 2");
      end
      if (SAMPLE_CODE == 0 || SAMPLE_CODE >= (1 << IR_W) - 1) begin : g_bad_smp
         $error("dual_use_test_port: SAMPLE_CODE clashes with EXTEST or BYPASS");
      end
   endgenerate

   // pin synchronisation: {trst, sel, ck, di, ms}
   logic [4:0] pins_s;
   logic trst_s, sel_s, ck_s, di_s, ms_s;

   tpp_pin_sync #(
      .W       (5),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (5'b10000)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({trst_n, sel_jtag, pin_ck, pin_di, pin_ms}),
      .q     (pins_s)
   );

   assign {trst_s, sel_s, ck_s, di_s, ms_s} = pins_s;

   logic ck_q, sel_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_q  <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         ck_q  <= ck_s;
         sel_q <= sel_s;
      end
   end

   logic ck_rise, ck_fall, sel_fell, sel_rose;
   assign ck_rise  = ck_s & ~ck_q;
   assign ck_fall  = ~ck_s & ck_q;
   assign sel_fell = sel_q & ~sel_s;
   assign sel_rose = ~sel_q & sel_s;

   // programming-mode flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_mode <= 1'b0;
      end else if (sel_fell) begin
         prog_mode <= 1'b1;
      end else if (sel_rose) begin
         prog_mode <= 1'b0;
      end
   end

   // test-port controller
   logic       hold, step;
   tap_state_e state;

   assign hold = !trst_s || !sel_s;
   assign step = ck_rise && sel_s;

   tpp_tap_fsm u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .step  (step),
      .tms   (ms_s),
      .state (state)
   );

   logic cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
   assign cap_dr = step && state == ST_CAP_DR;
   assign sh_dr  = step && state == ST_SH_DR;
   assign upd_dr = step && state == ST_UPD_DR;
   assign cap_ir = step && state == ST_CAP_IR;
   assign sh_ir  = step && state == ST_SH_IR;
   assign upd_ir = step && state == ST_UPD_IR;

   // instruction register
   logic [IR_W-1:0] ir_sh, ir;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ir_sh <= '0;
         ir    <= IR_BYP;
      end else if (hold || state == ST_TLR) begin
         ir    <= IR_BYP;
      end else begin
         if (cap_ir) begin
            ir_sh <= IR_CAP;
         end else if (sh_ir) begin
            ir_sh <= {di_s, ir_sh[IR_W-1:1]};
         end
         if (upd_ir) begin
            ir <= ir_sh;
         end
      end
   end

   logic bsel;
   assign bsel = (ir == IR_EXT) || (ir == IR_SMP);

   // bypass bit
   logic byp;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byp <= 1'b0;
      end else if (cap_dr) begin
         byp <= 1'b0;
      end else if (sh_dr) begin
         byp <= di_s;
      end
   end

   // boundary register
   logic              chain_tdo;
   logic [N_TRI-1:0]  upd_out, upd_oe;

   tpp_bscan_chain #(
      .N_TRI (N_TRI),
      .N_IN  (N_IN)
   ) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (cap_dr && bsel),
      .shift   (sh_dr && bsel),
      .update  (upd_dr && bsel),
      .tdi     (di_s),
      .pad_in  (pad_in),
      .sys_out (sys_out),
      .sys_oe  (sys_oe),
      .tdo_bit (chain_tdo),
      .upd_out (upd_out),
      .upd_oe  (upd_oe)
   );

   // data-out register, loaded on the falling test-clock edge
   logic tdo_q, tdo_en_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdo_q    <= 1'b0;
         tdo_en_q <= 1'b0;
      end else if (hold) begin
         tdo_en_q <= 1'b0;
      end else if (ck_fall) begin
         tdo_en_q <= (state == ST_SH_DR) || (state == ST_SH_IR);
         tdo_q    <= (state == ST_SH_IR) ? ir_sh[0] :
                     (bsel ? chain_tdo : byp);
      end
   end

   // programming path
   tpp_prog_shifter #(
      .PROG_W (PROG_W)
   ) u_prog (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (!sel_s),
      .edge_rise (ck_rise),
      .mode      (ms_s),
      .sdi       (di_s),
      .data      (prog_data),
      .ctl_valid (prog_ctl_valid),
      .ctl_bit   (prog_ctl_bit)
   );

   assign pin_do    = sel_s ? tdo_q : prog_data[0];
   assign pin_do_en = sel_s ? tdo_en_q : 1'b1;

   // pad steering
   logic extest_on;
   assign extest_on = sel_s && (ir == IR_EXT);

   generate
      for (genvar k = 0; k < N_TRI; k++) begin : g_pad
         always_comb begin
            if (prog_mode) begin
               pad_out[k] = 1'b0;
               pad_oe[k]  = 1'b0;
            end else if (extest_on) begin
               pad_out[k] = upd_out[k];
               pad_oe[k]  = upd_oe[k];
            end else begin
               pad_out[k] = sys_out[k];
               pad_oe[k]  = sys_oe[k];
            end
         end
      end
   endgenerate

   // R8: a falling select edge enters programming mode
   p_prog_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_fell |=> prog_mode);

   // R9: a rising select edge leaves programming mode
   p_prog_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rose |=> !prog_mode);

   // R3: Test-Logic-Reset leaves BYPASS selected
   p_ir_tlr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TLR) |=> ir == IR_BYP);

   // R7: data out turns on only from a shift state
   p_tdo_shift_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdo_en_q) |-> (state == ST_SH_DR || state == ST_SH_IR));

   // R8: no pad enable survives programming mode
   p_pads_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      prog_mode |-> pad_oe == '0);

endmodule

// File: tb/dual_use_test_port_test.sv
`timescale 1ns/1ps
module dual_use_test_port_test;

   localparam int NT   = 4;
   localparam int NI   = 2;
   localparam int PW   = 8;
   localparam int LEN  = 3 * NT + NI;
   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic trst_n = 1'b1;
   logic sel_jtag = 1'b1;
   logic pin_ms = 1'b0, pin_di = 1'b0, pin_ck = 1'b0;
   logic pin_do, pin_do_en, prog_mode, prog_ctl_valid, prog_ctl_bit;
   logic [PW-1:0] prog_data;
   logic [NT-1:0] sys_out = '0, sys_oe = '0;
   logic [NT+NI-1:0] pad_in = '0;
   logic [NT-1:0] pad_out, pad_oe;

   always #4 clk = ~clk;

   dual_use_test_port uut (
      .clk(clk), .rst_n(rst_n), .trst_n(trst_n), .sel_jtag(sel_jtag),
      .pin_ms(pin_ms), .pin_di(pin_di), .pin_ck(pin_ck),
      .pin_do(pin_do), .pin_do_en(pin_do_en), .prog_mode(prog_mode),
      .prog_data(prog_data), .prog_ctl_valid(prog_ctl_valid),
      .prog_ctl_bit(prog_ctl_bit), .sys_out(sys_out), .sys_oe(sys_oe),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;
   int ctl_cnt = 0;
   logic ctl_last = 1'b0;

   always @(posedge clk) begin
      if (rst_n && prog_ctl_valid) begin
         ctl_cnt  = ctl_cnt + 1;
         ctl_last = prog_ctl_bit;
      end
   end

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic tck(input logic tms, input logic tdi);
      pin_ms = tms;
      pin_di = tdi;
      wait_clk(HALF);
      pin_ck = 1'b1;
      wait_clk(HALF);
      pin_ck = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic tap_reset();
      repeat (5) tck(1'b1, 1'b0);
      tck(1'b0, 1'b0);
   endtask

   task automatic scan_ir(input logic [1:0] code, output logic [1:0] cap);
      tck(1, 0); tck(1, 0); tck(0, 0); tck(0, 0);
      for (int i = 0; i < 2; i++) begin
         cap[i] = pin_do;
         tck(i == 1, code[i]);
      end
      tck(1, 0); tck(0, 0);
   endtask

   task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
      dout = '0;
      tck(1, 0); tck(0, 0); tck(0, 0);
      for (int i = 0; i < n; i++) begin
         dout[i] = pin_do;
         tck(i == n - 1, din[i]);
      end
      tck(1, 0); tck(0, 0);
   endtask

   task automatic t_reset();
      check("R6 pads follow core after reset", {pad_out, pad_oe}, {sys_out, sys_oe});
      check("R9 prog_mode low after reset", prog_mode, 0);
      check("R7 data out disabled at idle", pin_do_en, 0);
   endtask

   task automatic t_ir_capture();
      logic [1:0] cap;
      tap_reset();
      scan_ir(2'b11, cap);
      check("R3 IR capture pattern", cap, 2'b01);
      check("R7 data out off in Run-Test/Idle", pin_do_en, 0);
   endtask

   task automatic t_tdo_fall();
      tck(1, 0); tck(0, 0);
      pin_ms = 1'b0;
      wait_clk(HALF);
      pin_ck = 1'b1;
      wait_clk(HALF);
      check("R7 enable waits for falling edge", pin_do_en, 0);
      pin_ck = 1'b0;
      wait_clk(HALF);
      check("R7 enable after falling edge in Shift-DR", pin_do_en, 1);
      tck(1, 0);
      check("R7 enable drops in Exit1-DR", pin_do_en, 0);
      tck(1, 0); tck(0, 0);
   endtask

   task automatic t_bypass();
      logic [1:0] cap;
      logic [63:0] dout;
      logic [7:0] din = 8'hA5;
      logic [7:0] pd;
      pd = prog_data;
      scan_ir(2'b11, cap);
      scan_dr({56'h0, din}, 8, dout);
      check("R4 bypass delays by one", dout[7:0], {din[6:0], 1'b0});
      scan_ir(2'b10, cap);
      din = 8'h3C;
      scan_dr({56'h0, din}, 8, dout);
      check("R3 code 10 acts as bypass", dout[7:0], {din[6:0], 1'b0});
      check("R1 test clock leaves prog_data alone", prog_data, pd);
   endtask

   task automatic t_sample();
      logic [1:0] cap;
      logic [63:0] dout;
      logic [LEN-1:0] exp;
      pad_in  = 6'b101101;
      sys_out = 4'b0110;
      sys_oe  = 4'b1010;
      for (int k = 0; k < NT; k++) begin
         exp[3*k]   = pad_in[k];
         exp[3*k+1] = sys_out[k];
         exp[3*k+2] = sys_oe[k];
      end
      for (int j = 0; j < NI; j++) exp[3*NT+j] = pad_in[NT+j];
      scan_ir(2'b01, cap);
      scan_dr(64'h0, LEN, dout);
      check("R5 sample chain order", dout[LEN-1:0], exp);
      check("R6 pads follow core under SAMPLE", {pad_out, pad_oe}, {sys_out, sys_oe});
   endtask

   task automatic load_extest(input logic [LEN-1:0] din);
      logic [1:0] cap;
      logic [63:0] dout;
      scan_ir(2'b00, cap);
      scan_dr({{(64-LEN){1'b0}}, din}, LEN, dout);
   endtask

   function automatic logic [2*NT-1:0] ext_pads(input logic [LEN-1:0] din);
      logic [NT-1:0] o, e;
      for (int k = 0; k < NT; k++) begin
         o[k] = din[3*k+1];
         e[k] = din[3*k+2];
      end
      return {o, e};
   endfunction

   task automatic t_extest();
      logic [LEN-1:0] din = 14'h2A5C;
      load_extest(din);
      check("R6 EXTEST drives pads from update", {pad_out, pad_oe}, ext_pads(din));
   endtask

   task automatic t_trst();
      logic [LEN-1:0] din = 14'h1B36;
      load_extest(din);
      check("R12 EXTEST active before TRST", {pad_out, pad_oe}, ext_pads(din));
      trst_n = 1'b0;
      pin_ms = 1'b0;
      wait_clk(HALF);
      trst_n = 1'b1;
      wait_clk(HALF);
      check("R12 TRST returns pads to core", {pad_out, pad_oe}, {sys_out, sys_oe});
      tck(0, 0);
   endtask

   task automatic t_tms_reset();
      logic [LEN-1:0] din = 14'h0F3A;
      load_extest(din);
      check("R2 EXTEST active before TMS reset", {pad_out, pad_oe}, ext_pads(din));
      repeat (5) tck(1, 0);
      check("R2 five TMS-high clocks cancel EXTEST", {pad_out, pad_oe}, {sys_out, sys_oe});
      tck(0, 0);
   endtask

   task automatic t_prog_entry();
      load_extest(14'h3FFF);
      sel_jtag = 1'b0;
      wait_clk(HALF);
      check("R8 prog_mode set on select fall", prog_mode, 1);
      check("R8 all pad enables off", pad_oe, '0);
      check("R10 data out enabled in programming", pin_do_en, 1);
   endtask

   task automatic t_prog_shift();
      logic [PW-1:0] w = 8'hC3;
      for (int i = 0; i < PW; i++) tck(1'b0, w[i]);
      check("R10 shifted word", prog_data, w);
      check("R10 SDO shows LSB", pin_do, w[0]);
      tck(1'b0, 1'b1);
      check("R10 one more shift enters MSB", prog_data, {1'b1, w[PW-1:1]});
   endtask

   task automatic t_prog_ctl();
      logic [PW-1:0] pd;
      int c0;
      pd = prog_data;
      c0 = ctl_cnt;
      tck(1'b1, 1'b1);
      check("R11 control edge keeps word", prog_data, pd);
      check("R11 one strobe", ctl_cnt, c0 + 1);
      check("R11 strobe bit high", ctl_last, 1);
      tck(1'b1, 1'b0);
      check("R11 strobe bit low", ctl_last, 0);
      check("R11 second strobe", ctl_cnt, c0 + 2);
   endtask

   task automatic t_prog_exit();
      logic [1:0] cap;
      pin_ms = 1'b0;
      sel_jtag = 1'b1;
      wait_clk(HALF);
      check("R9 prog_mode clears", prog_mode, 0);
      check("R9 TAP restarted, pads follow core", {pad_out, pad_oe}, {sys_out, sys_oe});
      check("R9 data out idle", pin_do_en, 0);
      tck(0, 0);
      scan_ir(2'b11, cap);
      check("R1 pins act as TAP again", cap, 2'b01);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(HALF);
      t_reset();
      t_ir_capture();
      t_tdo_fall();
      t_bypass();
      t_sample();
      t_extest();
      t_trst();
      t_tms_reset();
      t_prog_entry();
      t_prog_shift();
      t_prog_ctl();
      t_prog_exit();
      finish_run();
   end

endmodule